// File: doc/BRIEF.md
# Sub-word Compare-to-Predicate Unit

This block compares two 32-bit operands and turns the outcome into a pair of predicate bits. Each operand is first reduced to a chosen byte, a chosen halfword or the full word, and then widened by sign or zero extension. The second operand can instead come from a 16-bit immediate. The widened values are tested against one of eight relations. Signed or unsigned ordering is picked from the signedness of the two selections.

The relation result and its complement are each merged with a source predicate through the same boolean operation. The source predicate can be inverted before the merge. Both merged bits are registered and appear one cycle after an accepted input, together with a one-cycle valid strobe. The block is used in a shader-style integer datapath where one operation writes a predicate and its complement.

Top module: `vcp_unit`

## Requirements
- R1: The select code has four bits. Bit 3 set means sign extension and clear means zero extension. Bits 2:0 pick the field: 0 to 3 pick byte k (bits 8k+7:8k), 4 picks the low halfword, 5 picks the high halfword, and 6 or 7 pick the full word.
- R2: When `b_use_imm` is 1, operand B is `b_imm`, sign-extended if `b_sel[3]` is 1 and zero-extended otherwise, and `b_data` has no effect. The field bits of `b_sel` still count toward the full-word test of R5.
- R3: When `a_sel[3]` equals `b_sel[3]`, the relation uses signed ordering if both are signed and unsigned ordering if both are unsigned.
- R4: When the signedness bits differ and neither field code is 6 or 7, the relation is evaluated as a signed comparison of the two widened values.
- R5: When the signedness bits differ and either field code is 6 or 7, the relation result is 0 for every relation code, including the always-true code.
- R6: Relation codes are 0 false, 1 less-than, 2 equal, 3 less-or-equal, 4 greater-than, 5 not-equal, 6 greater-or-equal and 7 true, each reading A relative to B.
- R7: The second predicate `q_out` is formed from the complement of the relation result, taken before the boolean merge.
- R8: The source predicate is `src_pred` XOR `src_pred_inv`. Both predicates are merged with it using code 0 AND, 1 OR or 2 XOR; code 3 acts as AND.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `p_out` and `q_out` update only on an accepted input and otherwise hold. Reset clears all three outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input operation accepted this cycle |
| a_data | input | 32 | Operand A register value |
| b_data | input | 32 | Operand B register value |
| b_imm | input | 16 | Immediate used for B when selected |
| b_use_imm | input | 1 | 1 selects the immediate for B |
| a_sel | input | 4 | Field and signedness select for A |
| b_sel | input | 4 | Field and signedness select for B |
| cmp_code | input | 3 | Relation code |
| bool_op | input | 2 | Boolean merge code |
| src_pred | input | 1 | Source predicate |
| src_pred_inv | input | 1 | Inverts the source predicate |
| p_out | output | 1 | Merged relation result |
| q_out | output | 1 | Merged complement result |
| out_valid | output | 1 | Result strobe |

## Verification
The hardest case to reach is the mixed-signedness boundary. At this boundary, a narrow field that widens to a large unsigned value has to be ordered against a negative value, and a full-word selection in the same situation has to force the result to false. Random operands seldom land close enough to the sign and lane edges to separate a signed ordering from an unsigned one. The stimulus therefore places byte, halfword and immediate values at those edges directly, including a full-word code paired with the always-true relation. A long random run then covers the other combinations, and a behavioural model that works on mathematical integer values checks every cycle.

// File: rtl/vcp_pkg.sv
package vcp_pkg;
   localparam int SEL_W = 4;
   localparam int CMP_W = 3;
   localparam int BOP_W = 2;

   typedef enum logic [CMP_W-1:0] {
      REL_NEVER = 3'd0,
      REL_LT    = 3'd1,
      REL_EQ    = 3'd2,
      REL_LE    = 3'd3,
      REL_GT    = 3'd4,
      REL_NE    = 3'd5,
      REL_GE    = 3'd6,
      REL_ALWAYS= 3'd7
   } vcp_rel_e;

   typedef enum logic [BOP_W-1:0] {
      MRG_AND  = 2'd0,
      MRG_OR   = 2'd1,
      MRG_XOR  = 2'd2,
      MRG_AND2 = 2'd3
   } vcp_mrg_e;

   // field codes 6 and 7 both name the full word
   function automatic logic sel_is_word(input logic [SEL_W-1:0] s);
      return s[2:1] == 2'b11;
   endfunction
endpackage

// File: rtl/vcp_lane_extract.sv
module vcp_lane_extract
   import vcp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] raw,
   input  logic [SEL_W-1:0]  sel,
   output logic [DATA_W-1:0] ext
);
   localparam int BYTE_W = DATA_W / 4;
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] byte_ext [4];
   logic [DATA_W-1:0] half_ext [2];

   for (genvar k = 0; k < 4; k++) begin : g_byte
      logic [BYTE_W-1:0] lane;
      assign lane        = raw[k*BYTE_W +: BYTE_W];
      assign byte_ext[k] = {{(DATA_W-BYTE_W){sel[3] & lane[BYTE_W-1]}}, lane};
   end

   for (genvar h = 0; h < 2; h++) begin : g_half
      logic [HALF_W-1:0] lane;
      assign lane        = raw[h*HALF_W +: HALF_W];
      assign half_ext[h] = {{(DATA_W-HALF_W){sel[3] & lane[HALF_W-1]}}, lane};
   end

   always_comb begin
      case (sel[2:0])
         3'd0, 3'd1, 3'd2, 3'd3: ext = byte_ext[sel[1:0]];
         3'd4:                   ext = half_ext[0];
         3'd5:                   ext = half_ext[1];
         default:                ext = raw;
      endcase
   end
endmodule

// File: rtl/vcp_imm_extend.sv
module vcp_imm_extend #(
   parameter int IMM_W  = 16,
   parameter int DATA_W = 32
) (
   input  logic [IMM_W-1:0]  imm,
   input  logic              sgn,
   output logic [DATA_W-1:0] ext
);
   if (IMM_W == DATA_W) begin : g_same
      logic unused_sgn;
      assign unused_sgn = sgn;
      assign ext        = imm;
   end else begin : g_widen
      assign ext = {{(DATA_W-IMM_W){sgn & imm[IMM_W-1]}}, imm};
   end
endmodule

// File: rtl/vcp_relation.sv
module vcp_relation
   import vcp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic [SEL_W-1:0]  a_sel,
   input  logic [SEL_W-1:0]  b_sel,
   input  logic [CMP_W-1:0]  code,
   output logic              hit
);
   logic mixed, any_word, use_signed, blocked;
   logic lt_s, lt_u, lt, eq;
   logic raw_hit;

   assign mixed      = a_sel[3] ^ b_sel[3];
   assign any_word   = sel_is_word(a_sel) | sel_is_word(b_sel);
   // mixed narrow fields both fit a signed word
   assign use_signed = mixed ? 1'b1 : a_sel[3];
   assign blocked    = mixed & any_word;

   assign lt_s = $signed(a) < $signed(b);
   assign lt_u = a < b;
   assign lt   = use_signed ? lt_s : lt_u;
   assign eq   = a == b;

   always_comb begin
      case (vcp_rel_e'(code))
         REL_NEVER:  raw_hit = 1'b0;
         REL_LT:     raw_hit = lt;
         REL_EQ:     raw_hit = eq;
         REL_LE:     raw_hit = lt | eq;
         REL_GT:     raw_hit = ~(lt | eq);
         REL_NE:     raw_hit = ~eq;
         REL_GE:     raw_hit = ~lt;
         default:    raw_hit = 1'b1;
      endcase
   end

   assign hit = raw_hit & ~blocked;
endmodule

// File: rtl/vcp_pred_merge.sv
module vcp_pred_merge
   import vcp_pkg::*;
(
   input  logic             res,
   input  logic             src,
   input  logic             src_inv,
   input  logic [BOP_W-1:0] op,
   output logic             y
);
   logic s;
   assign s = src ^ src_inv;

   always_comb begin
      case (vcp_mrg_e'(op))
         MRG_OR:  y = res | s;
         MRG_XOR: y = res ^ s;
         default: y = res & s;
      endcase
   end
endmodule

// File: rtl/vcp_unit.sv
module vcp_unit
   import vcp_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] a_data,
   input  logic [DATA_W-1:0] b_data,
   input  logic [IMM_W-1:0]  b_imm,
   input  logic              b_use_imm,
   input  logic [SEL_W-1:0]  a_sel,
   input  logic [SEL_W-1:0]  b_sel,
   input  logic [CMP_W-1:0]  cmp_code,
   input  logic [BOP_W-1:0]  bool_op,
   input  logic              src_pred,
   input  logic              src_pred_inv,
   output logic              p_out,
   output logic              q_out,
   output logic              out_valid
);
   localparam int N_PRED = 2;

   if (DATA_W % 4 != 0 || DATA_W < 8) begin : g_bad_data_w
      $error("vcp_unit: DATA_W must be a multiple of 4 and at least 8");
   end
   if (IMM_W < 1 || IMM_W > DATA_W) begin : g_bad_imm_w
      $error("vcp_unit: IMM_W must lie in 1..DATA_W");
   end

   logic [DATA_W-1:0] a_ext, b_reg_ext, b_imm_ext, b_ext;
   logic              rel_hit;
   logic [N_PRED-1:0] cand, merged;

   vcp_lane_extract #(.DATA_W(DATA_W)) u_a_lane (
      .raw (a_data),
      .sel (a_sel),
      .ext (a_ext)
   );

   vcp_lane_extract #(.DATA_W(DATA_W)) u_b_lane (
      .raw (b_data),
      .sel (b_sel),
      .ext (b_reg_ext)
   );

   vcp_imm_extend #(.IMM_W(IMM_W), .DATA_W(DATA_W)) u_b_imm (
      .imm (b_imm),
      .sgn (b_sel[3]),
      .ext (b_imm_ext)
   );

   assign b_ext = b_use_imm ? b_imm_ext : b_reg_ext;

   vcp_relation #(.DATA_W(DATA_W)) u_rel (
      .a     (a_ext),
      .b     (b_ext),
      .a_sel (a_sel),
      .b_sel (b_sel),
      .code  (cmp_code),
      .hit   (rel_hit)
   );

   assign cand = {~rel_hit, rel_hit};

   for (genvar i = 0; i < N_PRED; i++) begin : g_merge
      vcp_pred_merge u_merge (
         .res     (cand[i]),
         .src     (src_pred),
         .src_inv (src_pred_inv),
         .op      (bool_op),
         .y       (merged[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p_out     <= 1'b0;
         q_out     <= 1'b0;
         out_valid <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            p_out <= merged[0];
            q_out <= merged[1];
         end
      end
   end
endmodule

// File: rtl/vcp_unit_chk.sv
module vcp_unit_chk
   import vcp_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic [SEL_W-1:0] a_sel,
   input logic [SEL_W-1:0] b_sel,
   input logic [CMP_W-1:0] cmp_code,
   input logic [BOP_W-1:0] bool_op,
   input logic             src_pred,
   input logic             src_pred_inv,
   input logic             p_out,
   input logic             q_out,
   input logic             out_valid
);
   logic eff, blocked;
   assign eff     = src_pred ^ src_pred_inv;
   assign blocked = (a_sel[3] != b_sel[3]) && (sel_is_word(a_sel) || sel_is_word(b_sel));

   a_r9_valid_rise: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r9_valid_fall: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(p_out) && $stable(q_out));
   a_r7_xor_split: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && bool_op == 2'd2 |=> p_out != q_out);
   a_r8_and_zero: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && (bool_op == 2'd0 || bool_op == 2'd3) && !eff |=> !p_out && !q_out);
   a_r8_or_one: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && bool_op == 2'd1 && eff |=> p_out && q_out);
   a_r5_forced_false: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && blocked && bool_op == 2'd0 && eff |=> !p_out && q_out);
   a_r6_always: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && !blocked && cmp_code == 3'd7 && bool_op == 2'd0 && eff |=> p_out && !q_out);
   a_r6_never: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && cmp_code == 3'd0 && bool_op == 2'd0 && eff |=> !p_out && q_out);
endmodule

bind vcp_unit vcp_unit_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .in_valid     (in_valid),
   .a_sel        (a_sel),
   .b_sel        (b_sel),
   .cmp_code     (cmp_code),
   .bool_op      (bool_op),
   .src_pred     (src_pred),
   .src_pred_inv (src_pred_inv),
   .p_out        (p_out),
   .q_out        (q_out),
   .out_valid    (out_valid)
);

// File: tb/vcp_unit_tb.sv
`timescale 1ns/1ps
module vcp_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] a_data = '0, b_data = '0;
   logic [15:0] b_imm = '0;
   logic        b_use_imm = 1'b0;
   logic [3:0]  a_sel = '0, b_sel = '0;
   logic [2:0]  cmp_code = '0;
   logic [1:0]  bool_op = '0;
   logic        src_pred = 1'b0, src_pred_inv = 1'b0;
   logic        p_out, q_out, out_valid;

   int checks = 0;
   int errors = 0;
   logic exp_p = 1'b0, exp_q = 1'b0, exp_v = 1'b0;

   always #2.5 clk = ~clk;

   vcp_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_data(a_data), .b_data(b_data), .b_imm(b_imm), .b_use_imm(b_use_imm),
      .a_sel(a_sel), .b_sel(b_sel), .cmp_code(cmp_code), .bool_op(bool_op),
      .src_pred(src_pred), .src_pred_inv(src_pred_inv),
      .p_out(p_out), .q_out(q_out), .out_valid(out_valid)
   );

   // mathematical value of a selected field
   function automatic longint field_val(input logic [31:0] v, input logic [3:0] s);
      int w, sh;
      longint r;
      case (s[2:0])
         3'd0, 3'd1, 3'd2, 3'd3: begin w = 8;  sh = 8 * int'(s[1:0]); end
         3'd4:                   begin w = 16; sh = 0;  end
         3'd5:                   begin w = 16; sh = 16; end
         default:                begin w = 32; sh = 0;  end
      endcase
      r = longint'(v >> sh) & ((64'sd1 <<< w) - 1);
      if (s[3] && r[w-1]) r = r - (64'sd1 <<< w);
      return r;
   endfunction

   function automatic logic merge(input logic r, input logic s, input logic [1:0] op);
      if (op == 2'd1) return r | s;
      if (op == 2'd2) return r ^ s;
      return r & s;
   endfunction

   string cur_tag;

   task automatic model();
      longint av, bv;
      logic prim, s, word_any;
      av = field_val(a_data, a_sel);
      if (b_use_imm) begin
         bv = longint'(b_imm);
         if (b_sel[3] && b_imm[15]) bv = bv - 65536;
      end else bv = field_val(b_data, b_sel);
      word_any = (a_sel[2:1] == 2'b11) || (b_sel[2:1] == 2'b11);
      if (a_sel[3] != b_sel[3] && word_any) prim = 1'b0;
      else case (cmp_code)
         3'd0: prim = 1'b0;
         3'd1: prim = av <  bv;
         3'd2: prim = av == bv;
         3'd3: prim = av <= bv;
         3'd4: prim = av >  bv;
         3'd5: prim = av != bv;
         3'd6: prim = av >= bv;
         default: prim = 1'b1;
      endcase
      s = src_pred ^ src_pred_inv;
      exp_v = in_valid;
      if (in_valid) begin
         exp_p = merge(prim, s, bool_op);
         exp_q = merge(~prim, s, bool_op);
      end
   endtask

   task automatic check(input string tag);
      checks++;
      if (p_out !== exp_p || q_out !== exp_q || out_valid !== exp_v) begin
         errors++;
         $display("FAIL %s: actual p=%b q=%b v=%b expected p=%b q=%b v=%b",
                  tag, p_out, q_out, out_valid, exp_p, exp_q, exp_v);
      end
   endtask

   task automatic cycle(input string tag);
      model();
      @(negedge clk);
      check(tag);
   endtask

   task automatic vec(input logic [31:0] a, input logic [31:0] b, input logic [15:0] imm,
                      input logic ui, input logic [3:0] as, input logic [3:0] bs,
                      input logic [2:0] c, input logic [1:0] op, input logic sp,
                      input logic inv, input string tag);
      in_valid = 1'b1; a_data = a; b_data = b; b_imm = imm; b_use_imm = ui;
      a_sel = as; b_sel = bs; cmp_code = c; bool_op = op;
      src_pred = sp; src_pred_inv = inv;
      cycle(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk);
      check("R9 reset");
      @(negedge clk);
      rst_n = 1'b1;
      check("R9 reset release");

      vec(32'h0000_8000, 32'h0, 16'h0000, 1, 4'b1100, 4'b1100, 3'd1, 2'd0, 1, 0, "R1 signed half");
      vec(32'h0000_8000, 32'h0, 16'h0000, 1, 4'b0100, 4'b0100, 3'd1, 2'd0, 1, 0, "R1 unsigned half");
      vec(32'h00AB_0000, 32'h0000_00AB, 16'h0, 0, 4'b0010, 4'b0000, 3'd2, 2'd0, 1, 0, "R1 byte lanes");
      vec(32'h1234_5678, 32'h5678_0000, 16'h0, 0, 4'b0100, 4'b0101, 3'd2, 2'd0, 1, 0, "R1 high half");
      vec(32'hFFFF_FFFF, 32'h0, 16'hFFFF, 1, 4'b1110, 4'b1100, 3'd2, 2'd0, 1, 0, "R2 imm sign ext");
      vec(32'h0000_FFFF, 32'hDEAD_BEEF, 16'hFFFF, 1, 4'b0110, 4'b0110, 3'd2, 2'd0, 1, 0, "R2 imm zero ext");
      vec(32'hFFFF_FFFF, 32'h1, 16'h0, 0, 4'b0110, 4'b0110, 3'd4, 2'd0, 1, 0, "R3 unsigned word");
      vec(32'hFFFF_FFFF, 32'h1, 16'h0, 0, 4'b1110, 4'b1110, 3'd4, 2'd0, 1, 0, "R3 signed word");
      vec(32'h0000_0080, 32'h0000_00FF, 16'h0, 0, 4'b1000, 4'b0000, 3'd1, 2'd0, 1, 0, "R4 mixed bytes");
      vec(32'h0000_8000, 32'h0000_FFFF, 16'h0, 0, 4'b0100, 4'b1100, 3'd4, 2'd0, 1, 0, "R4 mixed halves");
      vec(32'h0000_0005, 32'h0000_0003, 16'h0, 0, 4'b0110, 4'b1000, 3'd7, 2'd0, 1, 0, "R5 word always");
      vec(32'h0000_0080, 32'h0, 16'h0001, 1, 4'b1000, 4'b0111, 3'd5, 2'd0, 1, 0, "R5 imm word code");
      for (int c = 0; c < 8; c++)
         vec(32'd3, 32'd5, 16'h0, 0, 4'b0110, 4'b0110, 3'(c), 2'd0, 1, 0, "R6 relation code");
      for (int op = 0; op < 4; op++)
         for (int sp = 0; sp < 2; sp++)
            for (int inv = 0; inv < 2; inv++)
               vec(32'd9, 32'd9, 16'h0, 0, 4'b0110, 4'b0110, 3'd2, 2'(op), 1'(sp), 1'(inv), "R7 R8 merge");

      in_valid = 1'b0; a_data = 32'h7; cmp_code = 3'd0; bool_op = 2'd1; src_pred = 1'b0;
      cycle("R9 hold idle");
      cycle("R9 hold idle again");

      for (int n = 0; n < 3000; n++) begin
         in_valid = ($urandom_range(3) != 0);
         a_data = $urandom; b_data = $urandom; b_imm = 16'($urandom);
         if ($urandom_range(1) == 1) begin
            a_data[7:0] = 8'h80; b_data[7:0] = 8'h7F;
         end
         b_use_imm = 1'($urandom);
         a_sel = 4'($urandom); b_sel = 4'($urandom);
         cmp_code = 3'($urandom); bool_op = 2'($urandom);
         src_pred = 1'($urandom); src_pred_inv = 1'($urandom);
         if (a_sel[3] != b_sel[3] && (a_sel[2:1] == 2'b11 || b_sel[2:1] == 2'b11)) cur_tag = "R5 random";
         else if (a_sel[3] != b_sel[3]) cur_tag = "R4 random";
         else cur_tag = "R3 random";
         cycle(cur_tag);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule